// File: doc/BRIEF.md
# I2C Master Command and Receive Queues

This block holds the queues that sit between software and the bit-level engine of a master-only I2C controller. Software reaches it through a small synchronous register window. A single data port carries transmit bytes and read requests in one direction and received bytes in the other. Bit 8 of a write selects which kind of entry is queued. The bit-level engine is outside the block. It takes command entries from the front of the transmit queue and pushes each byte it receives into the receive queue.

Two level registers give the current entry count of each queue. Two programmable thresholds set when the transmit-low and receive-ready status outputs assert. An enable register gates the whole path: while it is cleared, both queues are held empty. A transfer abort from the engine discards the contents of both queues. A write to a full transmit queue is dropped, and a read of an empty receive queue returns zero. Each of these misuses raises a one-cycle flag. A fixed identification word lets software confirm which block it is talking to.

Top module: `i2c_cmd_queue`

## Requirements
- R1: A bus write to the data port (offset 0x04) with bit 8 of the write data clear queues the command entry {1'b0, wdata[7:0]}. The engine sees it on `cmd_data` while `cmd_valid` is high, and a cycle with `cmd_pop` high removes it. Entries leave in the order they were written.
- R2: A data-port write with bit 8 set queues a read request, which the engine sees as `cmd_data[8]` = 1.
- R3: A bus read of the data port pops the oldest received byte. The byte appears zero-extended on `bus_rdata` from the clock edge that accepts the read, and received bytes come back in the order the engine pushed them.
- R4: The read-only level registers return the entry counts: offset 0x08 for the transmit queue and offset 0x0C for the receive queue.
- R5: `tx_low` is high exactly while the transmit level is less than or equal to the transmit threshold (offset 0x10).
- R6: `rx_ready` is high exactly while the receive level is greater than the receive threshold (offset 0x14).
- R7: A data-port write while the transmit queue holds DEPTH entries is dropped. The level does not change, the queued entries are unaffected, and `tx_over` is high for the one cycle after that write.
- R8: A data-port read while the receive queue is empty returns 0, and `rx_under` is high for the one cycle after that read.
- R9: A one-cycle `abort` pulse leaves both queue levels at 0 after the next clock edge.
- R10: The enable register (offset 0x00, bit 0) reads back as written. While it is 0, both queues are empty, data-port writes and engine pushes are ignored, and `cmd_valid` is low.
- R11: Offset 0x18 reads the fixed identification word 0x44570140.
- R12: After reset the enable bit, both thresholds and both levels read 0. `tx_low` is high and `rx_ready` is low.
- R13: The threshold registers keep only as many low bits as the level counter of their queue (4 bits for a depth of 8). Higher written bits read back as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe for this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered at the accepting edge |
| cmd_valid | output | 1 | Transmit queue has an entry for the engine |
| cmd_data | output | 9 | Front command entry: bit 8 = read request, bits 7:0 = byte |
| cmd_pop | input | 1 | Engine takes the front command entry |
| rx_push | input | 1 | Engine delivers a received byte |
| rx_byte | input | 8 | Received byte |
| abort | input | 1 | Transfer abort: discard both queues |
| tx_low | output | 1 | Transmit level at or below threshold |
| rx_ready | output | 1 | Receive level above threshold |
| tx_over | output | 1 | One-cycle flag: write to a full transmit queue dropped |
| rx_under | output | 1 | One-cycle flag: read of an empty receive queue |

## Verification
The assertions assume that the engine raises `cmd_pop` only while `cmd_valid` is high, and that it stays silent on `rx_push` while an abort is in flight. They also assume at most one bus access per cycle. The bench drives every input one half period away from the active edge and pops commands only after it has seen `cmd_valid`. It raises `abort` only as an isolated one-cycle pulse, so the inputs never leave those limits. Overflow and underflow are reached only through the register window, as a real driver would reach them.

// File: rtl/i2cq_pkg.sv
package i2cq_pkg;

    // Register offsets (byte addresses)
    localparam logic [7:0] OFF_ENABLE = 8'h00;
    localparam logic [7:0] OFF_DATA   = 8'h04;
    localparam logic [7:0] OFF_TX_LVL = 8'h08;
    localparam logic [7:0] OFF_RX_LVL = 8'h0C;
    localparam logic [7:0] OFF_TX_THR = 8'h10;
    localparam logic [7:0] OFF_RX_THR = 8'h14;
    localparam logic [7:0] OFF_IDENT  = 8'h18;

    localparam logic [31:0] IDENT_WORD = 32'h4457_0140;

    // Command entry: bit 8 selects read request, bits 7:0 carry the byte
    localparam int CMD_W   = 9;
    localparam int CMD_RD  = 8;
    localparam int BYTE_W  = 8;

    typedef enum logic [1:0] {
        CMP_AT_OR_BELOW = 2'd0,
        CMP_ABOVE       = 2'd1
    } cmp_mode_e;

endpackage

// File: rtl/i2cq_fifo.sv
module i2cq_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 8,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic [CNT_W-1:0] count,
    output logic             full,
    output logic             empty
);

    typedef struct packed {
        logic [DEPTH-1:0][WIDTH-1:0] mem;
        logic [PTR_W-1:0]            wptr;
        logic [PTR_W-1:0]            rptr;
        logic [CNT_W-1:0]            cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;

    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    logic do_push, do_pop;

    always_comb begin
        st_d    = st_q;
        do_push = push && (st_q.cnt != FULL_CNT);
        do_pop  = pop && (st_q.cnt != '0);
        if (flush) begin
            st_d.wptr = '0;
            st_d.rptr = '0;
            st_d.cnt  = '0;
        end else begin
            if (do_push) begin
                st_d.mem[st_q.wptr] = din;
                st_d.wptr = (st_q.wptr == LAST_PTR) ? '0 : st_q.wptr + PTR_W'(1);
            end
            if (do_pop) begin
                st_d.rptr = (st_q.rptr == LAST_PTR) ? '0 : st_q.rptr + PTR_W'(1);
            end
            if (do_push && !do_pop) begin
                st_d.cnt = st_q.cnt + CNT_W'(1);
            end else if (do_pop && !do_push) begin
                st_d.cnt = st_q.cnt - CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dout  = st_q.mem[st_q.rptr];
    assign count = st_q.cnt;
    assign full  = (st_q.cnt == FULL_CNT);
    assign empty = (st_q.cnt == '0);

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= FULL_CNT); // R7

    AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (count == '0)); // R9

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !flush |=> ((count == $past(count)) ||
                    (count == $past(count) + CNT_W'(1)) ||
                    (count + CNT_W'(1) == $past(count)))); // R4

endmodule

// File: rtl/i2cq_level_cmp.sv
module i2cq_level_cmp
    import i2cq_pkg::*;
#(
    parameter int        W    = 4,
    parameter cmp_mode_e MODE = CMP_AT_OR_BELOW
) (
    input  logic [W-1:0] level,
    input  logic [W-1:0] thr,
    output logic         hit
);

    generate
        if (MODE == CMP_ABOVE) begin : g_above
            assign hit = (level > thr);
        end else begin : g_below
            assign hit = (level <= thr);
        end
    endgenerate

endmodule

// File: rtl/i2cq_regs.sv
module i2cq_regs
    import i2cq_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int TX_LVL_W = 4,
    parameter int RX_LVL_W = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_sel,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    input  logic [TX_LVL_W-1:0] tx_level,
    input  logic [RX_LVL_W-1:0] rx_level,
    input  logic                tx_full,
    input  logic                rx_empty,
    input  logic [BYTE_W-1:0]   rx_head,
    output logic                enable,
    output logic [TX_LVL_W-1:0] tx_thr,
    output logic [RX_LVL_W-1:0] rx_thr,
    output logic                tx_push,
    output logic [CMD_W-1:0]    tx_entry,
    output logic                rx_pop,
    output logic                tx_over,
    output logic                rx_under
);

    typedef struct packed {
        logic                enable;
        logic [TX_LVL_W-1:0] tx_thr;
        logic [RX_LVL_W-1:0] rx_thr;
        logic [31:0]         rdata;
        logic                tx_over;
        logic                rx_under;
    } regs_st_t;

    regs_st_t st_d, st_q;

    logic wr_cyc, rd_cyc;
    logic hit_enable, hit_data, hit_tx_lvl, hit_rx_lvl;
    logic hit_tx_thr, hit_rx_thr, hit_ident;

    assign wr_cyc = bus_sel && bus_wr;
    assign rd_cyc = bus_sel && !bus_wr;

    assign hit_enable = (bus_addr == ADDR_W'(OFF_ENABLE));
    assign hit_data   = (bus_addr == ADDR_W'(OFF_DATA));
    assign hit_tx_lvl = (bus_addr == ADDR_W'(OFF_TX_LVL));
    assign hit_rx_lvl = (bus_addr == ADDR_W'(OFF_RX_LVL));
    assign hit_tx_thr = (bus_addr == ADDR_W'(OFF_TX_THR));
    assign hit_rx_thr = (bus_addr == ADDR_W'(OFF_RX_THR));
    assign hit_ident  = (bus_addr == ADDR_W'(OFF_IDENT));

    always_comb begin
        st_d          = st_q;
        st_d.tx_over  = 1'b0;
        st_d.rx_under = 1'b0;

        tx_push  = wr_cyc && hit_data && st_q.enable && !tx_full;
        tx_entry = bus_wdata[CMD_W-1:0];
        rx_pop   = rd_cyc && hit_data && !rx_empty;

        if (wr_cyc) begin
            if (hit_enable) begin
                st_d.enable = bus_wdata[0];
            end
            if (hit_tx_thr) begin
                st_d.tx_thr = bus_wdata[TX_LVL_W-1:0];
            end
            if (hit_rx_thr) begin
                st_d.rx_thr = bus_wdata[RX_LVL_W-1:0];
            end
            if (hit_data && st_q.enable && tx_full) begin
                st_d.tx_over = 1'b1;
            end
        end

        if (rd_cyc) begin
            st_d.rdata = '0;
            if (hit_enable) begin
                st_d.rdata = 32'(st_q.enable);
            end else if (hit_data) begin
                if (rx_empty) begin
                    st_d.rx_under = 1'b1;
                end else begin
                    st_d.rdata = 32'(rx_head);
                end
            end else if (hit_tx_lvl) begin
                st_d.rdata = 32'(tx_level);
            end else if (hit_rx_lvl) begin
                st_d.rdata = 32'(rx_level);
            end else if (hit_tx_thr) begin
                st_d.rdata = 32'(st_q.tx_thr);
            end else if (hit_rx_thr) begin
                st_d.rdata = 32'(st_q.rx_thr);
            end else if (hit_ident) begin
                st_d.rdata = IDENT_WORD;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bus_rdata = st_q.rdata;
    assign enable    = st_q.enable;
    assign tx_thr    = st_q.tx_thr;
    assign rx_thr    = st_q.rx_thr;
    assign tx_over   = st_q.tx_over;
    assign rx_under  = st_q.rx_under;

    logic unused_wdata;
    assign unused_wdata = ^bus_wdata[31:CMD_W];

    AST_UNDER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rx_under |-> (bus_rdata == '0)); // R8

    AST_OVER_NO_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cyc && hit_data && tx_full) |-> !tx_push); // R7

endmodule

// File: rtl/i2c_cmd_queue.sv
module i2c_cmd_queue
    import i2cq_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int TX_DEPTH = 8,
    parameter int RX_DEPTH = 8,
    localparam int TX_LVL_W = $clog2(TX_DEPTH + 1),
    localparam int RX_LVL_W = $clog2(RX_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              cmd_valid,
    output logic [8:0]        cmd_data,
    input  logic              cmd_pop,
    input  logic              rx_push,
    input  logic [7:0]        rx_byte,
    input  logic              abort,
    output logic              tx_low,
    output logic              rx_ready,
    output logic              tx_over,
    output logic              rx_under
);

    logic                enable;
    logic [TX_LVL_W-1:0] tx_level, tx_thr;
    logic [RX_LVL_W-1:0] rx_level, rx_thr;
    logic                tx_full, tx_empty, rx_full, rx_empty;
    logic                tx_push, rx_pop;
    logic [CMD_W-1:0]    tx_entry;
    logic [BYTE_W-1:0]   rx_head;
    logic                flush;

    assign flush = abort || !enable;

    i2cq_regs #(
        .ADDR_W   (ADDR_W),
        .TX_LVL_W (TX_LVL_W),
        .RX_LVL_W (RX_LVL_W)
    ) i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .tx_level  (tx_level),
        .rx_level  (rx_level),
        .tx_full   (tx_full),
        .rx_empty  (rx_empty),
        .rx_head   (rx_head),
        .enable    (enable),
        .tx_thr    (tx_thr),
        .rx_thr    (rx_thr),
        .tx_push   (tx_push),
        .tx_entry  (tx_entry),
        .rx_pop    (rx_pop),
        .tx_over   (tx_over),
        .rx_under  (rx_under)
    );

    i2cq_fifo #(
        .WIDTH (CMD_W),
        .DEPTH (TX_DEPTH)
    ) i_tx_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (flush),
        .push  (tx_push),
        .din   (tx_entry),
        .pop   (cmd_pop && cmd_valid),
        .dout  (cmd_data),
        .count (tx_level),
        .full  (tx_full),
        .empty (tx_empty)
    );

    i2cq_fifo #(
        .WIDTH (BYTE_W),
        .DEPTH (RX_DEPTH)
    ) i_rx_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (flush),
        .push  (rx_push && enable),
        .din   (rx_byte),
        .pop   (rx_pop),
        .dout  (rx_head),
        .count (rx_level),
        .full  (rx_full),
        .empty (rx_empty)
    );

    assign cmd_valid = enable && !tx_empty;

    i2cq_level_cmp #(
        .W    (TX_LVL_W),
        .MODE (CMP_AT_OR_BELOW)
    ) i_tx_cmp (
        .level (tx_level),
        .thr   (tx_thr),
        .hit   (tx_low)
    );

    i2cq_level_cmp #(
        .W    (RX_LVL_W),
        .MODE (CMP_ABOVE)
    ) i_rx_cmp (
        .level (rx_level),
        .thr   (rx_thr),
        .hit   (rx_ready)
    );

    logic unused_rx_full;
    assign unused_rx_full = rx_full;

    AST_CMD_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |-> !cmd_valid); // R10

    AST_ABORT_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> (tx_level == '0 && rx_level == '0)); // R9

    AST_POP_ONLY_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_pop && cmd_valid && !abort && enable && !tx_push)
            |=> (tx_level + TX_LVL_W'(1) == $past(tx_level))); // R1

endmodule

// File: tb/test_i2c_cmd_queue.sv
module test_i2c_cmd_queue;

    localparam int DEPTH = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        cmd_valid;
    logic [8:0]  cmd_data;
    logic        cmd_pop = 1'b0, rx_push = 1'b0, abort = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic        tx_low, rx_ready, tx_over, rx_under;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk; // 50 MHz

    i2c_cmd_queue i_i2c_cmd_queue (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cmd_valid(cmd_valid), .cmd_data(cmd_data), .cmd_pop(cmd_pop),
        .rx_push(rx_push), .rx_byte(rx_byte), .abort(abort),
        .tx_low(tx_low), .rx_ready(rx_ready), .tx_over(tx_over), .rx_under(rx_under)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic eng_pop(output logic [8:0] v, output logic vld);
        @(negedge clk);
        v = cmd_data; vld = cmd_valid;
        cmd_pop = cmd_valid;
        @(negedge clk);
        cmd_pop = 1'b0;
    endtask

    task automatic eng_push(input logic [7:0] b);
        @(negedge clk);
        rx_push = 1'b1; rx_byte = b;
        @(negedge clk);
        rx_push = 1'b0;
    endtask

    task automatic do_abort();
        @(negedge clk);
        abort = 1'b1;
        @(negedge clk);
        abort = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        check("R12 tx_low", 32'(tx_low), 1);
        check("R12 rx_ready", 32'(rx_ready), 0);
        rd(8'h00, d); check("R12 enable", d, 0);
        rd(8'h08, d); check("R12 tx level", d, 0);
        rd(8'h0C, d); check("R12 rx level", d, 0);
        rd(8'h10, d); check("R12 tx thr", d, 0);
        rd(8'h14, d); check("R12 rx thr", d, 0);
        rd(8'h18, d); check("R11 ident", d, 32'h4457_0140);
    endtask

    task automatic t_cmd_kinds();
        logic [31:0] d; logic [8:0] v; logic vld;
        wr(8'h00, 1); rd(8'h00, d); check("R10 enable readback", d, 1);
        wr(8'h04, 32'h05A);
        wr(8'h04, 32'h100);
        rd(8'h08, d); check("R4 tx level 2", d, 2);
        eng_pop(v, vld); check("R1 valid", 32'(vld), 1); check("R1 byte entry", 32'(v), 32'h05A);
        eng_pop(v, vld); check("R2 read request", 32'(v), 32'h100);
        rd(8'h08, d); check("R4 tx level 0", d, 0);
        @(negedge clk); check("R1 valid drops", 32'(cmd_valid), 0);
    endtask

    task automatic t_thresholds();
        logic [31:0] d;
        wr(8'h10, 2);
        wr(8'h04, 1); check("R5 lvl1 thr2", 32'(tx_low), 1);
        wr(8'h04, 2); check("R5 lvl2 thr2", 32'(tx_low), 1);
        wr(8'h04, 3); check("R5 lvl3 thr2", 32'(tx_low), 0);
        wr(8'h14, 1);
        eng_push(8'hA1); check("R6 lvl1 thr1", 32'(rx_ready), 0);
        eng_push(8'hB2); check("R6 lvl2 thr1", 32'(rx_ready), 1);
        rd(8'h0C, d); check("R4 rx level 2", d, 2);
        rd(8'h04, d); check("R3 first byte", d, 32'hA1);
        rd(8'h04, d); check("R3 second byte", d, 32'hB2);
        rd(8'h0C, d); check("R3 rx drained", d, 0);
        do_abort();
        wr(8'h10, 0); wr(8'h14, 0);
    endtask

    task automatic t_overflow();
        logic [31:0] d; logic [8:0] v; logic vld;
        for (int i = 0; i < DEPTH; i++) wr(8'h04, 32'(8'h10 + i));
        check("R7 no flag when filling", 32'(tx_over), 0);
        wr(8'h04, 32'h0EE);
        check("R7 tx_over pulse", 32'(tx_over), 1);
        @(negedge clk); check("R7 pulse one cycle", 32'(tx_over), 0);
        rd(8'h08, d); check("R7 level held", d, DEPTH);
        for (int i = 0; i < DEPTH; i++) begin
            eng_pop(v, vld);
            check("R7 queued order", 32'(v), 32'(8'h10 + i));
        end
        @(negedge clk); check("R7 dropped entry absent", 32'(cmd_valid), 0);
    endtask

    task automatic t_underflow();
        logic [31:0] d;
        rd(8'h04, d);
        check("R8 empty read zero", d, 0);
        check("R8 rx_under pulse", 32'(rx_under), 1);
        @(negedge clk); check("R8 pulse one cycle", 32'(rx_under), 0);
    endtask

    task automatic t_abort();
        logic [31:0] d;
        wr(8'h04, 32'h011); wr(8'h04, 32'h100);
        eng_push(8'h55);
        do_abort();
        rd(8'h08, d); check("R9 tx flushed", d, 0);
        rd(8'h0C, d); check("R9 rx flushed", d, 0);
        check("R9 no command", 32'(cmd_valid), 0);
    endtask

    task automatic t_disable();
        logic [31:0] d;
        wr(8'h04, 32'h022);
        wr(8'h00, 0);
        rd(8'h00, d); check("R10 disable readback", d, 0);
        rd(8'h08, d); check("R10 tx emptied", d, 0);
        wr(8'h04, 32'h033);
        eng_push(8'h44);
        rd(8'h08, d); check("R10 write ignored", d, 0);
        rd(8'h0C, d); check("R10 push ignored", d, 0);
        check("R10 cmd_valid low", 32'(cmd_valid), 0);
        wr(8'h00, 1);
    endtask

    task automatic t_thr_width();
        logic [31:0] d;
        wr(8'h10, 32'hFFFF); rd(8'h10, d); check("R13 tx thr width", d, 32'hF);
        wr(8'h14, 32'h1235); rd(8'h14, d); check("R13 rx thr width", d, 32'h5);
        wr(8'h10, 0); wr(8'h14, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_cmd_kinds();
        t_thresholds();
        t_overflow();
        t_underflow();
        t_abort();
        t_disable();
        t_thr_width();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule